// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a clock-level model of a pipelined burst SRAM. It has a small internal word array and the control logic that sorts every rising edge into one cycle kind: deselect, begin read, begin write, continue (advance) or suspend (hold). Two address strobes start a cycle. One belongs to the processor side and one to the controller side. Once a cycle has started, an advance input steps a two-bit burst counter through four word addresses, in either linear or interleaved order. Three chip enables gate the start of a cycle. A global write, a byte-write enable and four byte selects together form the write qualifier and the byte strobes.

Read data leave through a registered output stage. The output-enable flag is combinational in the active-low output enable, so it acts without waiting for a clock. It is forced low during write cycles and on the first read after a deselect. The data port reads as zero whenever the output-enable flag is low, which stands in for a high-impedance bus. A sleep input parks the block: while it is high, and for two edges after it falls, every cycle is treated as a deselect.

Top module: `burst_sram_ctl`

## Requirements
- R1: A strobe cycle begins only when ce1_n is low, ce2 is high and ce3_n is low. A controller-strobe cycle with ce2 low or ce3_n high is a deselect. A deselect ends any burst, and after it, edges with both strobes high remain deselects with no output.
- R2: With adsp_n low and ce1_n low, a selected device always begins a read at `addr`, whatever the write controls are. The array is not written in that cycle.
- R3: When adsc_n is low and the processor strobe does not take effect, a selected device begins at `addr`. It begins a write if the write qualifier is active and a read if it is not.
- R4: The write qualifier is active when gw_n is low, or when bwe_n is low and at least one bit of bw_n is low. When gw_n is low, all four bytes are written. Otherwise byte i (din bits 8i+7..8i) is written only when bwe_n and bw_n[i] are both low.
- R5: While a burst is active and both strobes are high, adv_n low moves to the next burst address and adv_n high keeps the current one. The cycle reads or writes according to the write qualifier, including burst writes that follow a processor-strobe read.
- R6: The upper address bits stay at the base. When lin is 1, the low two bits are base+k modulo 4. When lin is 0, they are base XOR k, where k is the burst count.
- R7: The word read at an edge appears on dout after that edge and stays there until the next read edge.
- R8: dout_en is high only when the last cycle was a read and oe_n is low now. It follows oe_n without a clock, it is low after any write cycle, and dout is zero whenever dout_en is low.
- R9: A begin-read edge reached from the deselected state leaves dout_en low for the cycle that follows it. A begin read inside an active burst does not.
- R10: With ce1_n high, the processor strobe is ignored, and a controller strobe with ce1_n high is a deselect.
- R11: While zz is high, and for two edges after zz is sampled low, every edge is a deselect. Nothing is written and dout_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | External word address |
| din | input | NB*BW | Write data |
| dout | output | NB*BW | Read data, zero when not driven |
| dout_en | output | 1 | Data output driven |

## Verification
If the burst counter or the order logic goes wrong, the next continue read returns a word from the wrong location. If a byte strobe is wrong, the error stays hidden in the array until that address is read back. The bench therefore reads every written word again with a separate single read. If the active or first-read flags are wrong, dout_en shows the wrong level in the very next cycle. If the sleep recovery count is wrong, an ignored write lands, or a valid one is lost, and a readback shows it.

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl #(
  parameter int AW = 6,
  parameter int BW = 8,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce1_n,
  input  logic               ce2,
  input  logic               ce3_n,
  input  logic               adsp_n,
  input  logic               adsc_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [NB-1:0]      bw_n,
  input  logic               oe_n,
  input  logic               zz,
  input  logic               lin,
  input  logic [AW-1:0]      addr,
  input  logic [NB*BW-1:0]   din,
  output logic [NB*BW-1:0]   dout,
  output logic               dout_en
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] base_q, nbase;
  logic [1:0]    cnt_q, ncnt, rec_q;
  logic          act_q, rd_q, first_q;
  logic [DW-1:0] dq_q;
  logic          start, burst, desel, do_rd, do_wr;
  logic [AW-1:0] eff;
  logic [NB-1:0] be;

  wire sel     = !ce1_n && ce2 && !ce3_n;
  wire wq      = !gw_n || (!bwe_n && !(&bw_n));
  wire blocked = zz || (rec_q != 2'd0);
  wire p_go    = !adsp_n && !ce1_n;

  always_comb begin
    start = 1'b0;
    burst = 1'b0;
    desel = 1'b0;
    if (blocked)              desel = 1'b1;
    else if (p_go || !adsc_n) begin
      if (sel) start = 1'b1;
      else     desel = 1'b1;
    end else if (act_q)       burst = 1'b1;
    nbase = start ? addr : base_q;
    ncnt  = start ? 2'd0 : (burst ? cnt_q + {1'b0, !adv_n} : cnt_q);
    do_rd = (start && (p_go || !wq)) || (burst && !wq);
    do_wr = (start && !p_go && wq) || (burst && wq);
  end

  assign eff = {nbase[AW-1:2], lin ? nbase[1:0] + ncnt : nbase[1:0] ^ ncnt};
  assign be  = !do_wr ? '0 : (!gw_n ? '1 : (bwe_n ? '0 : ~bw_n));

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (be[i]) mem[eff][i*BW +: BW] <= din[i*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      first_q <= 1'b0;
      dq_q    <= '0;
      rec_q   <= '0;
    end else begin
      base_q  <= nbase;
      cnt_q   <= ncnt;
      act_q   <= start || (act_q && !desel);
      rd_q    <= do_rd;
      first_q <= do_rd && start && !act_q;
      if (do_rd) dq_q <= mem[eff];
      if (zz)                 rec_q <= 2'd2;
      else if (rec_q != 2'd0) rec_q <= rec_q - 2'd1;
    end
  end

  assign dout_en = rd_q && !first_q && !oe_n;
  assign dout    = dout_en ? dq_q : '0;

  p_en_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (rd_q && !oe_n));
  p_strobe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && sel && !blocked) |=> (rd_q && act_q));
  p_write_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (be != '0) |-> (!gw_n || (!bwe_n && !(&bw_n))));
  p_proc_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_go |-> (be == '0));
  p_ce1_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && ce1_n) |=> (!rd_q && !act_q));
  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (!dout_en && !act_q));
  p_sleep_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (be == '0));
endmodule

// File: tb/sim_burst_sram_ctl.sv
`timescale 1ns/1ps
module sim_burst_sram_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz, lin;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [31:0] din, dout;
  logic        dout_en;
  logic [31:0] rf [64];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_sram_ctl u0 (.clk, .rst_n, .ce1_n, .ce2, .ce3_n, .adsp_n, .adsc_n, .adv_n,
    .gw_n, .bwe_n, .bw_n, .oe_n, .zz, .lin, .addr, .din, .dout, .dout_en);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; zz = 0; din = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [5:0] ba(input logic [5:0] b, input int k, input logic l);
    logic [1:0] kk = 2'(k);
    return {b[5:2], l ? b[1:0] + kk : b[1:0] ^ kk};
  endfunction

  task automatic desel();
    idle(); adsc_n = 0; ce2 = 0; step(); idle();
  endtask

  task automatic rd1(input string tag, input logic [5:0] a, input logic gwx);
    desel();
    adsp_n = 0; addr = a; gw_n = gwx; din = 32'hDEAD_BEEF; step();
    chk({tag, " R9 first read masked"}, {31'b0, dout_en}, 32'd0);
    idle(); step();
    chk({tag, " R7 data"}, dout, rf[a]);
    chk({tag, " R8 en"}, {31'b0, dout_en}, 32'd1);
  endtask

  task automatic wr_burst(input logic [5:0] b, input logic l, input logic [31:0] seed);
    idle(); lin = l;
    adsc_n = 0; addr = b; gw_n = 0; din = seed; step();
    rf[b] = seed;
    chk("R8 masked on write", {31'b0, dout_en}, 32'd0);
    for (int k = 1; k < 4; k++) begin
      adsc_n = 1; adv_n = 0; din = seed + 32'(k); step();
      rf[ba(b, k, l)] = seed + 32'(k);
    end
    idle();
  endtask

  initial begin
    idle(); lin = 1; addr = '0;
    repeat (2) step();
    chk("R8 reset en", {31'b0, dout_en}, 32'd0);
    chk("R8 reset dout", dout, 32'd0);
    rst_n = 1; step();
    for (int i = 0; i < 64; i++) begin
      adsc_n = 0; gw_n = 0; addr = 6'(i); din = 32'h1000_0000 + 32'(i * 32'h0101); step();
      rf[i] = 32'h1000_0000 + 32'(i * 32'h0101);
    end
    idle();
    for (int i = 0; i < 64; i += 5) rd1("R3 fill", 6'(i), 1'b1);

    for (int l = 0; l < 2; l++)
      for (int o = 0; o < 4; o++) begin
        logic [5:0] b = 6'(32 + l * 8 + o);
        wr_burst(b, 1'(l), 32'hA000_0000 + 32'(l * 256 + o * 16));
        for (int k = 0; k < 4; k++) rd1("R6 order", ba(b, k, 1'(l)), 1'b1);
        desel(); lin = 1'(l);
        adsp_n = 0; addr = b; step(); idle(); step();
        chk("R5 burst first", dout, rf[b]);
        for (int k = 1; k < 4; k++) begin
          adv_n = 0; step();
          chk("R5 continue read", dout, rf[ba(b, k, 1'(l))]);
          chk("R8 en in burst", {31'b0, dout_en}, 32'd1);
        end
        adv_n = 1; step();
        chk("R5 suspend holds", dout, rf[ba(b, 3, 1'(l))]);
      end

    lin = 1;
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d = 32'h5A00_0000 | 32'(m * 32'h1111);
      idle(); adsc_n = 0; addr = 6'(16 + m); bwe_n = 0; bw_n = 4'(m); din = d; step();
      for (int i = 0; i < 4; i++) if (!m[i]) rf[16 + m][i*8 +: 8] = d[i*8 +: 8];
      idle();
      rd1("R4 byte mask", 6'(16 + m), 1'b1);
    end
    idle(); adsc_n = 0; addr = 6'd2; gw_n = 1; bwe_n = 1; bw_n = 4'h0; din = 32'hFFFF_FFFF; step();
    chk("R3 bwe high is read", {31'b0, dout_en}, 32'd1);
    idle(); rd1("R4 no write when bwe high", 6'd2, 1'b1);

    rd1("R2 proc strobe ignores write", 6'd7, 1'b0);
    idle(); desel(); adsp_n = 0; addr = 6'd8; step();
    adsp_n = 1; adv_n = 0; gw_n = 0; din = 32'hC0DE_0009; step();
    rf[9] = 32'hC0DE_0009;
    chk("R5 write after proc read en", {31'b0, dout_en}, 32'd0);
    idle(); rd1("R5 write after proc read", 6'd9, 1'b1);

    idle(); adsp_n = 0; addr = 6'd40; step();
    chk("R9 back to back not masked", {31'b0, dout_en}, 32'd1);
    chk("R9 back to back data", dout, rf[40]);
    idle(); oe_n = 1; #1;
    chk("R8 oe high", {31'b0, dout_en}, 32'd0);
    chk("R8 dout zero", dout, 32'd0);
    oe_n = 0; #1;
    chk("R8 oe async", {31'b0, dout_en}, 32'd1);
    @(negedge clk);

    idle(); adsp_n = 0; addr = 6'd44; step();
    idle(); ce1_n = 1; adsp_n = 0; adv_n = 0; lin = 1; step();
    chk("R10 proc strobe ignored", dout, rf[45]);
    idle(); ce1_n = 1; adsc_n = 0; step();
    chk("R10 ctrl strobe ce1 high", {31'b0, dout_en}, 32'd0);
    idle(); step();
    chk("R1 stays deselected", {31'b0, dout_en}, 32'd0);
    idle(); adsp_n = 0; addr = 6'd44; step(); idle(); step();
    idle(); adsc_n = 0; ce3_n = 1; step();
    chk("R1 ce3 high deselect", {31'b0, dout_en}, 32'd0);
    idle(); adsc_n = 0; ce2 = 0; step();
    chk("R1 ce2 low deselect", {31'b0, dout_en}, 32'd0);

    idle(); adsp_n = 0; addr = 6'd50; step(); idle(); step();
    zz = 1; step();
    chk("R11 sleep output off", {31'b0, dout_en}, 32'd0);
    step();
    zz = 0; adsc_n = 0; gw_n = 0; addr = 6'd50; din = 32'hBAD0_0001; step();
    chk("R11 recovery off", {31'b0, dout_en}, 32'd0);
    addr = 6'd51; din = 32'hBAD0_0002; step();
    addr = 6'd52; din = 32'h600D_0052; step();
    rf[52] = 32'h600D_0052;
    idle();
    rd1("R11 recovery edge 1 ignored", 6'd50, 1'b1);
    rd1("R11 recovery edge 2 ignored", 6'd51, 1'b1);
    rd1("R11 third edge writes", 6'd52, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule